// File: doc/BRIEF.md
# Global History Direction Predictor

This block predicts whether a conditional branch will be taken by looking at the pattern of outcomes of the most recent branches, whichever branches they were. A shift register of resolved outcomes (1 for taken, 0 for not taken) forms the first level. Its value selects one entry of a table of 2-bit saturating counters, which forms the second level. The upper bit of the selected counter is the prediction.

The front end presents a fetch address on the lookup side. It receives the predicted direction and a copy of the history value used to form the index, all in the same cycle. When the branch resolves, the back end returns the branch address, the real outcome and that saved copy of the history on the update side. The counter named by the saved copy is trained, and the real outcome is shifted into the live history.

A parameter picks how the index is built. In plain mode the history alone forms the index. In hashed mode the history is XORed with address bits [HIST_W+1:2], which spreads unrelated branches that share a history pattern across different counters.

Top module: `ghp_predictor`

## Requirements
- R1: After reset the history is all zeros and every counter holds 01, so each lookup returns not taken with a history copy of zero.
- R2: The prediction is bit 1 of the selected counter. Counter values 00 and 01 mean not taken, and 10 and 11 mean taken.
- R3: An update with outcome taken raises the addressed counter by one, and it stays at 11 once it gets there.
- R4: An update with outcome not taken lowers the addressed counter by one, and it stays at 00 once it gets there.
- R5: On each update the outcome enters history bit 0, every other bit moves up one place, and the top bit is dropped. The lookup side shows the history as it was before that clock edge.
- R6: In plain mode (HASH_EN=0) the index equals the history, and the lookup address has no effect on the prediction.
- R7: In hashed mode (HASH_EN=1) the index is the history XOR address bits [HIST_W+1:2], for both lookup and update.
- R8: An update trains the counter named by the history copy it carries, even when the live history has moved on since the lookup.
- R9: While the update valid input is low, neither the history nor any counter changes.
- R10: A lookup that selects the counter being written in the same cycle returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_pc | input | PC_W | Address of the branch being looked up |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_hist | output | HIST_W | History value used for this lookup |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Real outcome, 1 = taken |
| upd_hist | input | HIST_W | History copy returned by the lookup of that branch |

## Verification
The hardest case to reach is training a counter and then reading that same counter back. Every update moves the live history, so a later lookup normally lands on a different entry. The bench trains with a fixed, stale history copy. It then works out, from the live history it has predicted, the lookup address that XORs back onto the trained index in hashed mode. It also drives an update and a lookup onto one entry in the same cycle, to show that reads happen before writes. A behavioural model compares both index modes against the design on every clock, over directed and random outcome streams.

// File: rtl/ghp_pkg.sv
package ghp_pkg;

   typedef logic [1:0] sat2_t;

   localparam sat2_t SAT2_RESET = 2'b01;
   localparam sat2_t SAT2_MAX   = 2'b11;
   localparam sat2_t SAT2_MIN   = 2'b00;

   function automatic sat2_t sat2_step(input sat2_t cur, input logic up);
      sat2_t nxt;
      if (up) begin
         nxt = (cur == SAT2_MAX) ? cur : cur + 2'd1;
      end else begin
         nxt = (cur == SAT2_MIN) ? cur : cur - 2'd1;
      end
      return nxt;
   endfunction

   function automatic logic sat2_dir(input sat2_t cur);
      return cur[1];
   endfunction

endpackage

// File: rtl/ghp_hist_reg.sv
module ghp_hist_reg #(
   parameter int HIST_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift_en,
   input  logic              shift_bit,
   output logic [HIST_W-1:0] hist
);

   logic [HIST_W-1:0] hist_q;
   logic [HIST_W-1:0] hist_d;

   always_comb begin
      hist_d = hist_q;
      if (shift_en) begin
         hist_d = {hist_q[HIST_W-2:0], shift_bit};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist_q <= '0;
      end else begin
         hist_q <= hist_d;
      end
   end

   assign hist = hist_q;

endmodule

// File: rtl/ghp_index.sv
module ghp_index #(
   parameter int HIST_W  = 8,
   parameter int PC_W    = 32,
   parameter bit HASH_EN = 1'b1
) (
   input  logic [HIST_W-1:0] hist,
   input  logic [PC_W-1:0]   pc,
   output logic [HIST_W-1:0] idx
);

   localparam int PC_LO = 2;
   localparam int PC_HI = HIST_W + PC_LO - 1;

   logic pc_unused;
   assign pc_unused = ^pc;

   generate
      if (HASH_EN) begin : g_hashed
         logic [HIST_W-1:0] pc_slice;
         assign pc_slice = pc[PC_HI:PC_LO];
         assign idx      = hist ^ pc_slice;
      end else begin : g_plain
         assign idx = hist;
      end
   endgenerate

endmodule

// File: rtl/ghp_pht.sv
module ghp_pht
   import ghp_pkg::*;
#(
   parameter int IDX_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   output sat2_t            rd_cnt,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic             wr_up,
   output sat2_t            wr_old,
   output sat2_t            wr_new
);

   localparam int DEPTH = 1 << IDX_W;

   sat2_t cnt_q [DEPTH];

   assign rd_cnt = cnt_q[rd_idx];
   assign wr_old = cnt_q[wr_idx];
   assign wr_new = sat2_step(wr_old, wr_up);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int e = 0; e < DEPTH; e++) begin
            cnt_q[e] <= SAT2_RESET;
         end
      end else if (wr_en) begin
         cnt_q[wr_idx] <= wr_new;
      end
   end

endmodule

// File: rtl/ghp_predictor.sv
module ghp_predictor
   import ghp_pkg::*;
#(
   parameter int HIST_W  = 8,
   parameter int PC_W    = 32,
   parameter bit HASH_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PC_W-1:0]   lk_pc,
   output logic              pred_taken,
   output logic [HIST_W-1:0] pred_hist,
   input  logic              upd_valid,
   input  logic [PC_W-1:0]   upd_pc,
   input  logic              upd_taken,
   input  logic [HIST_W-1:0] upd_hist
);

   localparam int MIN_HIST = 2;
   localparam int MAX_HIST = 16;
   localparam int PC_NEED  = HIST_W + 2;

   generate
      if (HIST_W < MIN_HIST || HIST_W > MAX_HIST) begin : g_bad_hist
         $error("ghp_predictor: HIST_W out of supported range");
      end
      if (HASH_EN && PC_W < PC_NEED) begin : g_bad_pc
         $error("ghp_predictor: PC_W too narrow for hashed index");
      end
   endgenerate

   logic [HIST_W-1:0] live_hist;
   logic [HIST_W-1:0] lk_idx;
   logic [HIST_W-1:0] up_idx;
   sat2_t             lk_cnt;
   sat2_t             upd_cnt_old;
   sat2_t             upd_cnt_new;

   ghp_hist_reg #(
      .HIST_W (HIST_W)
   ) u_hist (
      .clk       (clk),
      .rst_n     (rst_n),
      .shift_en  (upd_valid),
      .shift_bit (upd_taken),
      .hist      (live_hist)
   );

   ghp_index #(
      .HIST_W  (HIST_W),
      .PC_W    (PC_W),
      .HASH_EN (HASH_EN)
   ) u_lk_index (
      .hist (live_hist),
      .pc   (lk_pc),
      .idx  (lk_idx)
   );

   ghp_index #(
      .HIST_W  (HIST_W),
      .PC_W    (PC_W),
      .HASH_EN (HASH_EN)
   ) u_up_index (
      .hist (upd_hist),
      .pc   (upd_pc),
      .idx  (up_idx)
   );

   ghp_pht #(
      .IDX_W (HIST_W)
   ) u_pht (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_idx (lk_idx),
      .rd_cnt (lk_cnt),
      .wr_en  (upd_valid),
      .wr_idx (up_idx),
      .wr_up  (upd_taken),
      .wr_old (upd_cnt_old),
      .wr_new (upd_cnt_new)
   );

   assign pred_taken = sat2_dir(lk_cnt);
   assign pred_hist  = live_hist;

endmodule

// File: rtl/ghp_predictor_chk.sv
module ghp_predictor_chk #(
   parameter int HIST_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [HIST_W-1:0] pred_hist,
   input logic              upd_valid,
   input logic              upd_taken,
   input logic [1:0]        upd_cnt_old,
   input logic [1:0]        upd_cnt_new
);

   // R1: history is zero on the first cycle out of reset
   p_reset_hist_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (pred_hist == '0));

   // R5: the outcome enters at bit 0 and older bits move up
   p_hist_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
      upd_valid |=> (pred_hist == {$past(pred_hist[HIST_W-2:0]), $past(upd_taken)}));

   // R9: history holds while no update is presented
   p_hist_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_valid |=> $stable(pred_hist));

   // R3: a taken update raises the counter, stopping at 11
   p_cnt_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_valid && upd_taken) |->
         ((upd_cnt_old != 2'b11 && upd_cnt_new == upd_cnt_old + 2'd1) ||
          (upd_cnt_old == 2'b11 && upd_cnt_new == 2'b11)));

   // R4: a not-taken update lowers the counter, stopping at 00
   p_cnt_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_valid && !upd_taken) |->
         ((upd_cnt_old != 2'b00 && upd_cnt_new == upd_cnt_old - 2'd1) ||
          (upd_cnt_old == 2'b00 && upd_cnt_new == 2'b00)));

endmodule

bind ghp_predictor ghp_predictor_chk #(
   .HIST_W (HIST_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .pred_hist   (pred_hist),
   .upd_valid   (upd_valid),
   .upd_taken   (upd_taken),
   .upd_cnt_old (upd_cnt_old),
   .upd_cnt_new (upd_cnt_new)
);

// File: tb/ghp_predictor_tb_top.sv
module ghp_predictor_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int HW   = 6;
   localparam int PW   = 12;
   localparam int NENT = 1 << HW;
   localparam int HMSK = NENT - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [PW-1:0] lk_pc = '0;
   logic          upd_valid = 1'b0;
   logic [PW-1:0] upd_pc = '0;
   logic          upd_taken = 1'b0;
   logic [HW-1:0] upd_hist = '0;

   logic          h_taken, p_taken;
   logic [HW-1:0] h_hist, p_hist;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   int m_hash  [NENT];
   int m_plain [NENT];
   int m_ghr;

   always #(CLK_PERIOD/2) clk = ~clk;

   ghp_predictor #(.HIST_W(HW), .PC_W(PW), .HASH_EN(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .pred_taken(h_taken),
      .pred_hist(h_hist), .upd_valid(upd_valid), .upd_pc(upd_pc),
      .upd_taken(upd_taken), .upd_hist(upd_hist));

   ghp_predictor #(.HIST_W(HW), .PC_W(PW), .HASH_EN(1'b0)) dut_plain_i (
      .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .pred_taken(p_taken),
      .pred_hist(p_hist), .upd_valid(upd_valid), .upd_pc(upd_pc),
      .upd_taken(upd_taken), .upd_hist(upd_hist));

   function automatic int hidx(int hist, int pc);
      return (hist ^ (pc >> 2)) & HMSK;
   endfunction

   function automatic int sat(int c, bit up);
      if (up) return (c == 3) ? 3 : c + 1;
      return (c == 0) ? 0 : c - 1;
   endfunction

   task automatic check(string tag, string what, int got, int exp);
      n_checks++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
      end
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   endtask

   // one cycle: drive, compare combinational lookup, clock, advance model
   task automatic step(string tag, int lpc, bit uv, int upc, bit ut, int uh);
      lk_pc     = PW'(lpc);
      upd_valid = uv;
      upd_pc    = PW'(upc);
      upd_taken = ut;
      upd_hist  = HW'(uh);
      #1;
      check("R5", "hashed history", int'(h_hist), m_ghr);
      check("R5", "plain history", int'(p_hist), m_ghr);
      check(tag, "hashed prediction", int'(h_taken), m_hash[hidx(m_ghr, lpc)] >> 1);
      check((tag == "R7") ? "R6" : tag, "plain prediction", int'(p_taken),
            m_plain[m_ghr] >> 1);
      @(posedge clk);
      if (uv) begin
         m_hash[hidx(uh, upc)] = sat(m_hash[hidx(uh, upc)], ut);
         m_plain[uh & HMSK]    = sat(m_plain[uh & HMSK], ut);
         m_ghr = ((m_ghr << 1) | int'(ut)) & HMSK;
      end
      @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
   end

   initial begin
      int tpc, hit_pc, snap;
      for (int e = 0; e < NENT; e++) begin
         m_hash[e]  = 1;
         m_plain[e] = 1;
      end
      m_ghr = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state under several lookup addresses
      check("R1", "hashed prediction after reset", int'(h_taken), 0);
      for (int k = 0; k < 4; k++) step("R1", k * 52 + 4, 1'b0, 0, 1'b0, 0);

      // R3 and R8: train one entry with a stale zero snapshot, saturate high
      tpc = 12'h0A4;
      for (int k = 0; k < 4; k++) step("R3", 0, 1'b1, tpc, 1'b1, 0);
      hit_pc = ((hidx(0, tpc) ^ m_ghr) & HMSK) << 2;
      step("R8", hit_pc, 1'b0, 0, 1'b0, 0);
      check("R3", "trained entry predicts taken", int'(h_taken), 1);

      // R4: drive the same entry down to 00 and past it
      for (int k = 0; k < 5; k++) step("R4", hit_pc, 1'b1, tpc, 1'b0, 0);
      hit_pc = ((hidx(0, tpc) ^ m_ghr) & HMSK) << 2;
      step("R4", hit_pc, 1'b0, 0, 1'b0, 0);
      check("R4", "detrained entry predicts not taken", int'(h_taken), 0);

      // R5: outcome pattern 1,0,1,1 shifted into history
      step("R5", 0, 1'b1, 8, 1'b1, m_ghr);
      step("R5", 0, 1'b1, 8, 1'b0, m_ghr);
      step("R5", 0, 1'b1, 8, 1'b1, m_ghr);
      step("R5", 0, 1'b1, 8, 1'b1, m_ghr);

      // R6 and R7: vary the lookup address at a fixed history
      for (int k = 0; k < 8; k++) step("R7", k * 36 + 3, 1'b0, 0, 1'b0, 0);

      // R8: update carries an old snapshot while live history differs
      snap = m_ghr ^ 6'h15;
      for (int k = 0; k < 3; k++) step("R8", 0, 1'b1, 12'h3C0, 1'b1, snap);

      // R9: no update valid, other update inputs toggling
      for (int k = 0; k < 6; k++) step("R9", k * 20, 1'b0, k * 44, k[0], k * 9);

      // R10: lookup and update hit the same entry in one cycle
      for (int k = 0; k < 4; k++) step("R10", 12'h1F0, 1'b1, 12'h1F0, 1'b1, m_ghr);

      // R2: random traffic with current and stale snapshots
      for (int k = 0; k < 400; k++) begin
         int r = $urandom;
         int uh = (r[3]) ? m_ghr : (r >> 8) & HMSK;
         step("R2", (r >> 4) & 12'hFFF, r[0], (r >> 16) & 12'hFFF, r[1] | r[2], uh);
      end

      summary();
   end

endmodule